// File: doc/BRIEF.md
# Receiver Equalizer Sweep Controller

This block is a hardware sequencer that searches for the best receive feed-forward equalizer setting on one serial lane. A single-cycle start pulse launches a run. The controller first enables signal-presence deglitching and clock-recovery lock detection. It then waits a fixed settle interval and confirms that a cable is present and that clock recovery has locked. If either check fails, the run ends at once with a failure.

When both checks succeed, every equalizer setting is tried in ascending order. For each setting the controller enables the pseudo-random pattern checker and waits a settle interval. It then applies the setting, raises the training start request and waits a bounded time for the training engine to answer. A clean completion yields a quality score. A failed completion or a timeout means the setting scores nothing. After each trial the pattern counters are cleared.

The highest strictly greater score wins. The winning setting is trained once more, and the outcome of that repeat run is what the block reports. The analog equalizer and the training engine sit outside this block and are reached through plain handshake ports.

States: `S_IDLE`, `S_SETTLE` (presence settle wait), `S_CHECK` (presence decision), `S_PAT_ON` (pattern enable), `S_PAT_WAIT` (pattern settle), `S_APPLY` (drive setting), `S_TRAIN` (request raised, polling), `S_CAPTURE` (request dropped, score taken), `S_CLEAR` (counter reset pulse, pattern off), `S_RELEASE` (reset released, next step chosen), `S_PICK` (winner selection), `S_FINISH` (done pulse).

Transitions:
- IDLE→SETTLE on start.
- SETTLE→CHECK when the settle timer expires.
- CHECK→FINISH when squelch is seen or lock is missing; CHECK→PAT_ON otherwise.
- PAT_ON→PAT_WAIT, then PAT_WAIT→APPLY on timer expiry, then APPLY→TRAIN.
- TRAIN→CAPTURE on a clean completion.
- TRAIN→CLEAR on a completion that carries the fail flag, or on timeout.
- CAPTURE→CLEAR, then CLEAR→RELEASE.
- RELEASE→FINISH after the confirmation run; RELEASE→PICK after the last sweep setting; RELEASE→PAT_ON otherwise.
- PICK→FINISH when the best score is zero; PICK→PAT_ON (confirmation run) otherwise.
- FINISH→IDLE.

Top module: `eq_sweep_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, train_start_o, pat_en_o, pat_clr_o and det_en_o are 0, and chosen_o and score_o are 0.
- R2: From the cycle after a start pulse until the done pulse, busy_o and det_en_o are 1.
- R3: Presence is judged only after DET_WAIT settle cycles. For an aborted run, done_o rises DET_WAIT+2 cycles after the cycle in which start_i was sampled. A squelch indication that clears before the settle wait ends does not abort the run.
- R4: If sig_absent_i is 1 at the presence check, the run ends with pass_o=0 and no training request is raised.
- R5: If cdr_lock_i is 0 at the presence check, the run ends with pass_o=0 and no training request is raised.
- R6: Settings 0 to NUM_SET-1 are tried in ascending order on eq_set_o. For each setting, pat_en_o is high for exactly PAT_WAIT+2 cycles before train_start_o rises. eq_set_o holds steady while train_start_o is high.
- R7: train_start_o stays high for at most TIMEOUT cycles. A trial that gets no completion within that window counts as failed.
- R8: A completion with train_fail_i=1 makes the trial failed, and its score is ignored.
- R9: After every trial, pat_clr_o pulses for one cycle while pat_en_o is 0.
- R10: The best setting changes only on a strictly greater successful score. Ties keep the lower setting.
- R11: If every trial scores 0 or fails, the run ends with pass_o=0, chosen_o=0 and score_o=0, without a confirmation trial.
- R12: Otherwise the winning setting is trained once more. pass_o reports that repeat trial's outcome, chosen_o reports the winner, and score_o reports the repeat score (0 on failure).
- R13: done_o is a one-cycle pulse after which busy_o is 0. A start pulse while busy_o is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| sig_absent_i | input | 1 | Squelch indication: 1 means no signal present |
| cdr_lock_i | input | 1 | Clock recovery locked |
| train_done_i | input | 1 | Training engine finished |
| train_fail_i | input | 1 | Training engine reports failure, valid with done |
| score_i | input | SCORE_W | Quality score from the training engine |
| det_en_o | output | 1 | Enable squelch deglitch and lock detection |
| pat_en_o | output | 1 | Enable pattern checker |
| pat_clr_o | output | 1 | Pattern counter reset |
| eq_set_o | output | SET_W | Equalizer setting applied |
| train_start_o | output | 1 | Training request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, one cycle |
| pass_o | output | 1 | Run result |
| chosen_o | output | SET_W | Reported setting |
| score_o | output | SCORE_W | Reported score |

## Verification
A corrupted trial index shows up on eq_set_o at the next training request. Within one trial, the logged order of settings diverges from the ascending sweep. A wrong best register or a broken strict-greater compare is visible only at the end of the sweep, when the confirmation trial uses the wrong setting. That happens roughly nine trials after start, and chosen_o and score_o then disagree with the table. Timer faults change how long pat_en_o and train_start_o stay high in the very first trial, and they change the done latency of an aborted run within DET_WAIT+2 cycles.

// File: rtl/eq_sweep_pkg.sv
package eq_sweep_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_SETTLE,
        S_CHECK,
        S_PAT_ON,
        S_PAT_WAIT,
        S_APPLY,
        S_TRAIN,
        S_CAPTURE,
        S_CLEAR,
        S_RELEASE,
        S_PICK,
        S_FINISH
    } sweep_state_e;
endpackage

// File: rtl/eq_sweep_timer.sv
module eq_sweep_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (dec_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/eq_sweep_best.sv
module eq_sweep_best #(
    parameter int SET_W   = 3,
    parameter int SCORE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               upd_i,
    input  logic [SET_W-1:0]   idx_i,
    input  logic [SCORE_W-1:0] score_i,
    output logic [SET_W-1:0]   best_idx_o,
    output logic [SCORE_W-1:0] best_score_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_idx_o   <= '0;
            best_score_o <= '0;
        end else if (clr_i) begin
            best_idx_o   <= '0;
            best_score_o <= '0;
        end else if (upd_i && score_i > best_score_o) begin
            best_idx_o   <= idx_i;
            best_score_o <= score_i;
        end
    end

    // R10: best score never falls during a sweep
    p_best_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> best_score_o >= $past(best_score_o));
    // R10: a tie or lower score leaves the winner alone
    p_tie_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && upd_i && score_i <= best_score_o) |=> $stable(best_idx_o));
endmodule

// File: rtl/eq_sweep_ctrl.sv
module eq_sweep_ctrl
    import eq_sweep_pkg::*;
#(
    parameter int NUM_SET  = 8,
    parameter int SCORE_W  = 6,
    parameter int TIMEOUT  = 500,
    parameter int DET_WAIT = 16,
    parameter int PAT_WAIT = 8,
    localparam int SET_W   = (NUM_SET > 1) ? $clog2(NUM_SET) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               sig_absent_i,
    input  logic               cdr_lock_i,
    input  logic               train_done_i,
    input  logic               train_fail_i,
    input  logic [SCORE_W-1:0] score_i,
    output logic               det_en_o,
    output logic               pat_en_o,
    output logic               pat_clr_o,
    output logic [SET_W-1:0]   eq_set_o,
    output logic               train_start_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               pass_o,
    output logic [SET_W-1:0]   chosen_o,
    output logic [SCORE_W-1:0] score_o
);
    localparam int TMR_MAX0 = (DET_WAIT > PAT_WAIT) ? DET_WAIT : PAT_WAIT;
    localparam int TMR_MAX  = (TMR_MAX0 > TIMEOUT) ? TMR_MAX0 : TIMEOUT;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SET - 1);

    sweep_state_e state_q, state_d;
    logic [SET_W-1:0]   cur_q;
    logic [SET_W-1:0]   eq_q;
    logic               confirm_q;
    logic               trial_ok_q;
    logic [SCORE_W-1:0] trial_score_q;
    logic               tmr_load, tmr_dec, tmr_zero;
    logic [TMR_W-1:0]   tmr_val;
    logic [SET_W-1:0]   best_idx;
    logic [SCORE_W-1:0] best_score;
    logic               best_clr, best_upd;

    eq_sweep_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val),
        .dec_i(tmr_dec), .zero_o(tmr_zero)
    );

    assign best_clr = (state_q == S_IDLE) && start_i;
    assign best_upd = (state_q == S_CAPTURE) && !confirm_q;

    eq_sweep_best #(.SET_W(SET_W), .SCORE_W(SCORE_W)) u_best (
        .clk(clk), .rst_n(rst_n), .clr_i(best_clr), .upd_i(best_upd),
        .idx_i(cur_q), .score_i(score_i),
        .best_idx_o(best_idx), .best_score_o(best_score)
    );

    // next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE: if (start_i) begin
                state_d  = S_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(DET_WAIT - 1);
            end
            S_SETTLE: if (tmr_zero) state_d = S_CHECK; else tmr_dec = 1'b1;
            S_CHECK: state_d = (sig_absent_i || !cdr_lock_i) ? S_FINISH : S_PAT_ON;
            S_PAT_ON: begin
                state_d  = S_PAT_WAIT;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(PAT_WAIT - 1);
            end
            S_PAT_WAIT: if (tmr_zero) state_d = S_APPLY; else tmr_dec = 1'b1;
            S_APPLY: begin
                state_d  = S_TRAIN;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(TIMEOUT - 1);
            end
            S_TRAIN: begin
                if (train_done_i)  state_d = train_fail_i ? S_CLEAR : S_CAPTURE;
                else if (tmr_zero) state_d = S_CLEAR;
                else               tmr_dec = 1'b1;
            end
            S_CAPTURE: state_d = S_CLEAR;
            S_CLEAR:   state_d = S_RELEASE;
            S_RELEASE: begin
                if (confirm_q)              state_d = S_FINISH;
                else if (cur_q == LAST_SET) state_d = S_PICK;
                else                        state_d = S_PAT_ON;
            end
            S_PICK:   state_d = (best_score == '0) ? S_FINISH : S_PAT_ON;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // trial bookkeeping and reported results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q         <= '0;
            eq_q          <= '0;
            confirm_q     <= 1'b0;
            trial_ok_q    <= 1'b0;
            trial_score_q <= '0;
            pass_o        <= 1'b0;
            chosen_o      <= '0;
            score_o       <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    cur_q     <= '0;
                    confirm_q <= 1'b0;
                end
                S_CHECK: if (sig_absent_i || !cdr_lock_i) begin
                    pass_o   <= 1'b0;
                    chosen_o <= '0;
                    score_o  <= '0;
                end
                S_APPLY: begin
                    eq_q       <= cur_q;
                    trial_ok_q <= 1'b0;
                end
                S_CAPTURE: begin
                    trial_ok_q    <= 1'b1;
                    trial_score_q <= score_i;
                end
                S_RELEASE: begin
                    if (confirm_q) begin
                        pass_o   <= trial_ok_q;
                        chosen_o <= cur_q;
                        score_o  <= trial_ok_q ? trial_score_q : '0;
                    end else if (cur_q != LAST_SET) begin
                        cur_q <= cur_q + 1'b1;
                    end
                end
                S_PICK: begin
                    if (best_score == '0) begin
                        pass_o   <= 1'b0;
                        chosen_o <= '0;
                        score_o  <= '0;
                    end else begin
                        cur_q     <= best_idx;
                        confirm_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Moore output decode
    always_comb begin
        busy_o        = (state_q != S_IDLE) && (state_q != S_FINISH);
        det_en_o      = busy_o;
        done_o        = (state_q == S_FINISH);
        train_start_o = (state_q == S_TRAIN);
        pat_clr_o     = (state_q == S_CLEAR);
        pat_en_o      = (state_q == S_PAT_ON) || (state_q == S_PAT_WAIT) ||
                        (state_q == S_APPLY)  || (state_q == S_TRAIN)    ||
                        (state_q == S_CAPTURE);
        eq_set_o      = eq_q;
    end

    // length of the current training request, for the bound check
    logic [TMR_W:0] train_cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              train_cyc_q <= '0;
        else if (!train_start_o) train_cyc_q <= '0;
        else                     train_cyc_q <= train_cyc_q + 1'b1;
    end

    p_train_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        train_cyc_q <= (TMR_W+1)'(TIMEOUT));
    p_pat_during_train_r6: assert property (@(posedge clk) disable iff (!rst_n)
        train_start_o |-> pat_en_o);
    p_eq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (train_start_o && $past(train_start_o)) |-> $stable(eq_set_o));
    p_clear_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pat_clr_o |=> (!pat_clr_o && !pat_en_o));
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
endmodule

// File: tb/eq_sweep_ctrl_bench.sv
`timescale 1ns/1ps
module eq_sweep_ctrl_bench;
    localparam int NUM_SET  = 8;
    localparam int SCORE_W  = 6;
    localparam int TIMEOUT  = 500;
    localparam int DET_WAIT = 16;
    localparam int PAT_WAIT = 8;
    localparam int LAT      = 3;
    localparam int NVEC     = 6;

    // per setting score {s7..s0}, kind {k7..k0} (0 ok, 1 fail flag, 2 silent)
    // expected {trials[3:0], pass, set[2:0], score[5:0]}
    localparam logic [47:0] V_SC [NVEC] = '{
        {6'd7, 6'd0, 6'd1, 6'd20, 6'd20, 6'd3, 6'd9, 6'd5},
        {6'd63, 6'd7, 6'd6, 6'd5, 6'd4, 6'd3, 6'd2, 6'd1},
        {6'd10, 6'd10, 6'd10, 6'd10, 6'd10, 6'd63, 6'd10, 6'd40},
        {6'd30, 6'd30, 6'd30, 6'd30, 6'd30, 6'd30, 6'd30, 6'd30},
        {6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0},
        {6'd2, 6'd2, 6'd50, 6'd2, 6'd2, 6'd2, 6'd30, 6'd2}
    };
    localparam logic [15:0] V_KD [NVEC] = '{
        16'h0000, 16'h0000, 16'h0010, 16'h5555, 16'h0000, 16'h0800
    };
    localparam logic [13:0] V_EXP [NVEC] = '{
        {4'd9, 1'b1, 3'd3, 6'd20},
        {4'd9, 1'b1, 3'd7, 6'd63},
        {4'd9, 1'b1, 3'd0, 6'd40},
        {4'd8, 1'b0, 3'd0, 6'd0},
        {4'd8, 1'b0, 3'd0, 6'd0},
        {4'd9, 1'b1, 3'd1, 6'd30}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic sig_absent_i = 1'b0;
    logic cdr_lock_i = 1'b1;
    logic train_done_i = 1'b0;
    logic train_fail_i = 1'b0;
    logic [SCORE_W-1:0] score_i = '0;
    logic det_en_o, pat_en_o, pat_clr_o, train_start_o, busy_o, done_o, pass_o;
    logic [2:0] eq_set_o, chosen_o;
    logic [SCORE_W-1:0] score_o;

    always #2 clk = ~clk;

    eq_sweep_ctrl #(.NUM_SET(NUM_SET), .SCORE_W(SCORE_W), .TIMEOUT(TIMEOUT),
                    .DET_WAIT(DET_WAIT), .PAT_WAIT(PAT_WAIT)) u_eq_sweep_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sig_absent_i(sig_absent_i),
        .cdr_lock_i(cdr_lock_i), .train_done_i(train_done_i), .train_fail_i(train_fail_i),
        .score_i(score_i), .det_en_o(det_en_o), .pat_en_o(pat_en_o), .pat_clr_o(pat_clr_o),
        .eq_set_o(eq_set_o), .train_start_o(train_start_o), .busy_o(busy_o),
        .done_o(done_o), .pass_o(pass_o), .chosen_o(chosen_o), .score_o(score_o)
    );

    int checks = 0;
    int errors = 0;
    int n_trials = 0;
    int n_clr = 0;
    int trial_log [16];
    logic [1:0] kind_a [8];
    logic [5:0] score_a [8];
    bit rerun_fail = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_vec(input int v);
        for (int s = 0; s < 8; s++) begin
            score_a[s] = V_SC[v][s*6 +: 6];
            kind_a[s]  = V_KD[v][s*2 +: 2];
        end
    endtask

    task automatic clear_log();
        n_trials = 0;
        n_clr = 0;
    endtask

    // pulse start, wait for done; returns cycles from start to done
    task automatic run(output int lat);
        lat = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        chk(busy_o && det_en_o, "R2 busy/det_en after start", int'(busy_o), 1);
        while (!done_o && lat < 20000) begin
            @(negedge clk);
            lat++;
            if (!done_o && (!busy_o || !det_en_o)) chk(1'b0, "R2 busy mid-run", int'(busy_o), 1);
        end
        chk(done_o, "R13 run reaches done", int'(done_o), 1);
    endtask

    // training engine model and port monitor
    initial begin
        bit prev_st = 1'b0;
        int pat_run = 0;
        int start_len = 0;
        int tcnt = 0;
        int last_set = 0;
        forever begin
            @(negedge clk);
            pat_run = pat_en_o ? pat_run + 1 : 0;
            if (train_start_o && !prev_st) begin
                if (n_trials < 16) trial_log[n_trials] = int'(eq_set_o);
                n_trials++;
                last_set = int'(eq_set_o);
                chk(pat_run == PAT_WAIT + 3, "R6 pattern settle before request", pat_run, PAT_WAIT + 3);
            end
            if (!train_start_o && prev_st && kind_a[last_set] == 2'd2)
                chk(start_len == TIMEOUT, "R7 timeout length", start_len, TIMEOUT);
            start_len = train_start_o ? start_len + 1 : 0;
            if (pat_clr_o) begin
                n_clr++;
                chk(!pat_en_o, "R9 pattern off during clear", int'(pat_en_o), 0);
            end
            if (train_start_o) begin
                tcnt++;
                if (tcnt >= LAT && kind_a[eq_set_o] != 2'd2) begin
                    train_done_i = 1'b1;
                    train_fail_i = (kind_a[eq_set_o] == 2'd1) || (rerun_fail && n_trials == 9);
                end else begin
                    train_done_i = 1'b0;
                    train_fail_i = 1'b0;
                end
            end else begin
                tcnt = 0;
                train_done_i = 1'b0;
                train_fail_i = 1'b0;
            end
            score_i = score_a[eq_set_o];
            prev_st = train_start_o;
        end
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        load_vec(0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !pass_o, "R1 reset flags", int'(busy_o | done_o | pass_o), 0);
        chk(!train_start_o && !pat_en_o && !pat_clr_o && !det_en_o, "R1 reset drives",
            int'(train_start_o | pat_en_o | pat_clr_o | det_en_o), 0);
        chk(chosen_o == 0 && score_o == 0, "R1 reset results", int'(score_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table of sweeps
        for (int v = 0; v < NVEC; v++) begin
            load_vec(v);
            clear_log();
            run(lat);
            chk(pass_o == V_EXP[v][9], $sformatf("R12 pass vec%0d", v), int'(pass_o), int'(V_EXP[v][9]));
            chk(chosen_o == V_EXP[v][8:6], $sformatf("R10 chosen vec%0d", v), int'(chosen_o), int'(V_EXP[v][8:6]));
            chk(score_o == V_EXP[v][5:0], $sformatf("R12 score vec%0d", v), int'(score_o), int'(V_EXP[v][5:0]));
            chk(n_trials == int'(V_EXP[v][13:10]), $sformatf("R11 trial count vec%0d", v), n_trials, int'(V_EXP[v][13:10]));
            chk(n_clr == n_trials, $sformatf("R9 clear pulses vec%0d", v), n_clr, n_trials);
            for (int t = 0; t < 8; t++)
                chk(trial_log[t] == t, $sformatf("R6 order vec%0d", v), trial_log[t], t);
            if (n_trials == 9)
                chk(trial_log[8] == int'(V_EXP[v][8:6]), $sformatf("R12 rerun setting vec%0d", v),
                    trial_log[8], int'(V_EXP[v][8:6]));
            if (v == 2) chk(score_o != 6'd63, "R8 failed score ignored", int'(score_o), 40);
            if (v == 5) chk(chosen_o != 3'd5, "R7 timed-out setting not chosen", int'(chosen_o), 1);
            if (v == 0) chk(chosen_o == 3'd3, "R10 tie keeps earlier", int'(chosen_o), 3);
            @(negedge clk);
            chk(!done_o && !busy_o, "R13 done single cycle", int'(done_o), 0);
        end

        // R4 squelch abort with settle latency (R3)
        load_vec(0);
        clear_log();
        sig_absent_i = 1'b1;
        run(lat);
        chk(lat == DET_WAIT + 2, "R3 abort latency", lat, DET_WAIT + 2);
        chk(!pass_o && n_trials == 0, "R4 squelch abort", n_trials, 0);
        sig_absent_i = 1'b0;

        // R5 lock missing abort
        clear_log();
        cdr_lock_i = 1'b0;
        run(lat);
        chk(!pass_o && n_trials == 0, "R5 lock abort", n_trials, 0);
        chk(lat == DET_WAIT + 2, "R5 abort latency", lat, DET_WAIT + 2);
        cdr_lock_i = 1'b1;

        // R3 squelch that clears during the settle wait does not abort
        clear_log();
        sig_absent_i = 1'b1;
        fork
            begin repeat (4) @(negedge clk); sig_absent_i = 1'b0; end
            run(lat);
        join
        chk(pass_o && n_trials == 9, "R3 squelch cleared before check", n_trials, 9);

        // R13 start while busy is ignored
        load_vec(1);
        clear_log();
        fork
            begin repeat (40) @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0; end
            run(lat);
        join
        chk(n_trials == 9 && chosen_o == 3'd7, "R13 busy start ignored", n_trials, 9);
        repeat (6) begin
            @(negedge clk);
            chk(!busy_o, "R13 no second run", int'(busy_o), 0);
        end

        // R12 rerun failing reports failure with the winner
        load_vec(0);
        clear_log();
        rerun_fail = 1'b1;
        run(lat);
        chk(!pass_o, "R12 rerun fail pass", int'(pass_o), 0);
        chk(chosen_o == 3'd3 && score_o == 0, "R12 rerun fail result", int'(score_o), 0);
        rerun_fail = 1'b0;

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule